// File: doc/BRIEF.md
# Dual-Mode Capture Write Controller

This block decides which samples a logic-analyzer capture FIFO stores, and it drives that FIFO's active-low write strobe and its data word. Its purpose is to make the stored words match the data stream of the target system exactly. It has two capture modes. In state mode the target's own clock sets the pace. That clock is synchronized into the sample-clock domain, and the block stores one word on each rising edge of the target clock where the qualifier input is high. In timing mode the block samples on every cycle of its own sample clock, asynchronously to the target. This sample clock is meant to run at five to ten times the target's operating frequency, and the only input that gates storage in this mode is the trigger word.

Software raises `arm` to start a capture. While armed, the block writes nothing until it sees the trigger word at a valid sample. The triggering sample is stored first, and a programmed number of further samples follows it. The block then reports `done` and holds it until `arm` is dropped. The mode select and the post-trigger length are taken in only while the block is disarmed. Each instance covers one acquisition slice of 32 data channels.

Top module: `acq_write_ctrl`

## Requirements
- R1: After reset, `fifo_wr_n` is 1 and `done` is 0.
- R2: The FIFO write strobe is active low and only strobes during an armed capture. It stays at 1 while the block is disarmed and while `done` is 1.
- R3: When `mode_sel` is 0 (timing mode) and a capture is running, every sample-clock cycle after the trigger stores one word. The stored words are the successive `din` values, in order and with no gaps.
- R4: When `mode_sel` is 1 (state mode), one word is stored for each rising edge of `ext_clk` that has `qual` at 1. A rising edge with `qual` at 0 stores nothing, and no two consecutive cycles carry a write.
- R5: In state mode the trigger word is only recognized at a qualified rising edge of `ext_clk`. A `trig` of 1 at an unqualified edge does not start storage.
- R6: While armed, nothing is written before the trigger sample. The first word written is the `din` value that was sampled together with `trig` at 1.
- R7: The value of `post_len` at arming sets the total number of words written: exactly `post_len`+1, counting the trigger sample. `done` rises after the last of them, and a `post_len` of 0 gives a single write.
- R8: Changes to `mode_sel` or `post_len` while armed have no effect on the capture in progress.
- R9: `done` stays at 1, and no writes occur, for as long as `arm` stays high. Dropping `arm` clears `done` and makes a new capture possible.
- R10: `fifo_data` carries the exact `din` word of the stored sample, on all channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arm | input | 1 | High to run a capture; low to disarm |
| mode_sel | input | 1 | 0 = timing mode, 1 = state mode; taken only while disarmed |
| post_len | input | 8 | Number of samples to store after the trigger sample |
| ext_clk | input | 1 | Target state clock, asynchronous |
| trig | input | 1 | Trigger word recognized |
| qual | input | 1 | Data qualifier for state mode |
| din | input | 32 | Target data channels |
| fifo_wr_n | output | 1 | Active-low FIFO write strobe |
| fifo_data | output | 32 | Word written to the FIFO |
| done | output | 1 | Capture complete |

## Verification
The assertions assume that `ext_clk` stays high for at least two sample-clock periods and low for at least two. This is what makes every synchronized edge a single-cycle pulse with a gap after it, and it is what makes back-to-back state-mode writes impossible. They also assume that `din`, `trig` and `qual` are steady around each target clock edge. The stimulus keeps within both assumptions: it holds the target clock at five cycles high and five cycles low, and it changes data and control only at the start of the low phase. In timing mode, data and trigger change once per sample cycle, away from the active edge.

// File: rtl/acq_pkg.sv
// Package: shared types for the capture write controller.
// Assumes nothing beyond SystemVerilog 2017 enum support.
package acq_pkg;

    // Capture sequencing states.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_CAPT = 2'd2,
        ST_DONE = 2'd3
    } acq_state_t;

    // Capture modes; encoding matches the mode_sel pin.
    typedef enum logic {
        MODE_TIMING = 1'b0,
        MODE_STATE  = 1'b1
    } acq_mode_t;

endpackage

// File: rtl/acq_edge_sync.sv
// Module: acq_edge_sync
// Brings an asynchronous clock-like signal into the sample domain through
// a parameterized flop chain and flags each rising edge with a one-cycle
// pulse. Assumes the input holds each level for at least two sample cycles.
module acq_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_o
);
    logic [SYNC_STAGES-1:0] chain;
    logic                   prev;

    // First synchronizer stage samples the raw input.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= async_in;
    end

    // Remaining stages shift the level along the chain.
    genvar g;
    generate
        for (g = 1; g < SYNC_STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= 1'b0;
                else        chain[g] <= chain[g-1];
            end
        end
    endgenerate

    // Remember the last synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= chain[SYNC_STAGES-1];
    end

    assign rise_o = chain[SYNC_STAGES-1] & ~prev;

    // R4: an edge pulse is never longer than one cycle.
    a_r4_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/acq_sample_gate.sv
// Module: acq_sample_gate
// Registers the target data, trigger and qualifier, and produces the
// sample-event strobe for the active mode: every cycle in timing mode, and
// a qualified synchronized edge in state mode. Assumes din/trig/qual are
// steady around each target clock edge.
module acq_sample_gate
    import acq_pkg::*;
#(
    parameter int W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  acq_mode_t       mode,
    input  logic            ext_rise,
    input  logic [W-1:0]    din,
    input  logic            trig,
    input  logic            qual,
    output logic [W-1:0]    smp_data,
    output logic            smp_trig,
    output logic            smp_event
);
    logic qual_r;

    // Input stage: capture data and control once per sample cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_data <= '0;
            smp_trig <= 1'b0;
            qual_r   <= 1'b0;
        end else begin
            smp_data <= din;
            smp_trig <= trig;
            qual_r   <= qual;
        end
    end

    // Select what counts as a sample in the current mode.
    always_comb begin
        if (mode == MODE_STATE) smp_event = ext_rise & qual_r;
        else                    smp_event = 1'b1;
    end

    // R4: an unqualified state-mode edge never yields a sample event.
    a_r4_unqualified: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_STATE && !qual_r) |-> !smp_event);

endmodule

// File: rtl/acq_write_fsm.sv
// Module: acq_write_fsm
// Sequences one capture: latches mode and post-trigger length while
// disarmed, waits for the trigger, emits post_len+1 active-low writes on
// sample events, then holds done until arm falls.
module acq_write_fsm
    import acq_pkg::*;
#(
    parameter int W  = 32,
    parameter int CW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            arm,
    input  logic            mode_sel,
    input  logic [CW-1:0]   post_len,
    input  logic            smp_event,
    input  logic            smp_trig,
    input  logic [W-1:0]    smp_data,
    output acq_mode_t       mode_q,
    output logic            fifo_wr_n,
    output logic [W-1:0]    fifo_data,
    output logic            done
);
    acq_state_t    state;
    logic [CW-1:0] len_q;
    logic [CW-1:0] remain;

    // Capture sequencer with registered FIFO strobe and data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            mode_q    <= MODE_TIMING;
            len_q     <= '0;
            remain    <= '0;
            fifo_wr_n <= 1'b1;
            fifo_data <= '0;
        end else begin
            fifo_wr_n <= 1'b1;
            case (state)
                ST_IDLE: begin
                    mode_q <= acq_mode_t'(mode_sel);
                    if (arm) begin
                        len_q <= post_len;
                        state <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (!arm) begin
                        state <= ST_IDLE;
                    end else if (smp_event && smp_trig) begin
                        fifo_wr_n <= 1'b0;
                        fifo_data <= smp_data;
                        remain    <= len_q;
                        state     <= (len_q == '0) ? ST_DONE : ST_CAPT;
                    end
                end
                ST_CAPT: begin
                    if (!arm) begin
                        state <= ST_IDLE;
                    end else if (smp_event) begin
                        fifo_wr_n <= 1'b0;
                        fifo_data <= smp_data;
                        remain    <= remain - 1'b1;
                        if (remain == CW'(1)) state <= ST_DONE;
                    end
                end
                default: begin
                    if (!arm) state <= ST_IDLE;
                end
            endcase
        end
    end

    assign done = (state == ST_DONE);

    // R2: no strobe follows a cycle spent disarmed or finished.
    a_r2_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_DONE) |=> fifo_wr_n);

    // R7: the remaining count stays within the latched length and nonzero.
    a_r7_remain_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CAPT) |-> (remain <= len_q && remain != '0));

    // R8: mode and length are frozen once armed.
    a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> ($stable(mode_q) && $stable(len_q)));

    // R9: done persists while arm stays high.
    a_r9_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && arm) |=> done);

endmodule

// File: rtl/acq_write_ctrl.sv
// Module: acq_write_ctrl (top)
// Capture FIFO write controller for one acquisition slice. Connects the
// target-clock synchronizer, the per-mode sample gate and the capture
// sequencer. Assumes ext_clk levels last at least two sample cycles.
module acq_write_ctrl
    import acq_pkg::*;
#(
    parameter int CHANNELS    = 32,
    parameter int LEN_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                arm,
    input  logic                mode_sel,
    input  logic [LEN_W-1:0]    post_len,
    input  logic                ext_clk,
    input  logic                trig,
    input  logic                qual,
    input  logic [CHANNELS-1:0] din,
    output logic                fifo_wr_n,
    output logic [CHANNELS-1:0] fifo_data,
    output logic                done
);
    logic                ext_rise;
    logic [CHANNELS-1:0] smp_data;
    logic                smp_trig;
    logic                smp_event;
    acq_mode_t           mode_q;

    acq_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_clk),
        .rise_o   (ext_rise)
    );

    acq_sample_gate #(.W(CHANNELS)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode_q),
        .ext_rise  (ext_rise),
        .din       (din),
        .trig      (trig),
        .qual      (qual),
        .smp_data  (smp_data),
        .smp_trig  (smp_trig),
        .smp_event (smp_event)
    );

    acq_write_fsm #(.W(CHANNELS), .CW(LEN_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .mode_sel  (mode_sel),
        .post_len  (post_len),
        .smp_event (smp_event),
        .smp_trig  (smp_trig),
        .smp_data  (smp_data),
        .mode_q    (mode_q),
        .fifo_wr_n (fifo_wr_n),
        .fifo_data (fifo_data),
        .done      (done)
    );

    // R4: state-mode writes never land on consecutive cycles.
    a_r4_state_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_wr_n && mode_q == MODE_STATE) |=> fifo_wr_n);

    // R2: a write is never issued while disarmed for two cycles running.
    a_r2_armed_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm && $past(!arm)) |-> fifo_wr_n);

endmodule

// File: tb/tb_acq_write_ctrl.sv
// Scoreboard bench: driver tasks queue expected words, a monitor pops and
// compares each FIFO write as it appears.
module tb_acq_write_ctrl;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         arm = 1'b0;
    logic         mode_sel = 1'b0;
    logic [7:0]   post_len = '0;
    logic         ext_clk = 1'b0;
    logic         trig = 1'b0;
    logic         qual = 1'b0;
    logic [W-1:0] din = '0;
    logic         fifo_wr_n;
    logic [W-1:0] fifo_data;
    logic         done;

    logic [W-1:0] exp_q[$];
    int checks = 0, errs = 0, mon_checks = 0, mon_errs = 0;

    always #2.5 clk = ~clk;

    acq_write_ctrl dut (
        .clk(clk), .rst_n(rst_n), .arm(arm), .mode_sel(mode_sel),
        .post_len(post_len), .ext_clk(ext_clk), .trig(trig), .qual(qual),
        .din(din), .fifo_wr_n(fifo_wr_n), .fifo_data(fifo_data), .done(done)
    );

    // Monitor: every write must match the head of the queue (R3-R7, R10).
    always @(negedge clk) begin
        if (rst_n && !fifo_wr_n) begin
            mon_checks++;
            if (exp_q.size() == 0) begin
                mon_errs++;
                $display("FAIL R2/R7: unexpected write act=%h exp=none", fifo_data);
            end else begin
                logic [W-1:0] e;
                e = exp_q.pop_front();
                if (fifo_data !== e) begin
                    mon_errs++;
                    $display("FAIL R10/R6: write data act=%h exp=%h", fifo_data, e);
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // One target clock period: set inputs in the low phase, then rise.
    task automatic state_cycle(input logic [W-1:0] d, input bit q, input bit t);
        @(negedge clk);
        ext_clk = 1'b0; din = d; qual = q; trig = t;
        repeat (5) @(negedge clk);
        ext_clk = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic disarm_check();
        repeat (5) @(negedge clk);
        check(done == 1'b1, "R9 done held", done, 1);
        arm = 1'b0;
        repeat (2) @(negedge clk);
        check(done == 1'b0, "R9 done cleared", done, 0);
        check(exp_q.size() == 0, "R7 all words written", exp_q.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(fifo_wr_n == 1'b1, "R1 wr_n reset", fifo_wr_n, 1);
        check(done == 1'b0, "R1 done reset", done, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Timing mode, trigger at word 20, five post samples (R3 R6 R7 R8).
        mode_sel = 1'b0; post_len = 8'd5;
        for (int k = 20; k <= 25; k++) exp_q.push_back(W'(k));
        arm = 1'b1;
        @(negedge clk);
        mode_sel = 1'b1; post_len = 8'd1;   // R8: must be ignored
        for (int i = 0; i <= 40; i++) begin
            din = W'(i); trig = (i == 20);
            @(negedge clk);
        end
        trig = 1'b0;
        check(done == 1'b1, "R7 done after timing capture", done, 1);
        disarm_check();

        // State mode, post_len 3 (R4 R5 R8 R10).
        mode_sel = 1'b1; post_len = 8'd3;
        exp_q.push_back(32'hA5A5_0003);
        exp_q.push_back(32'h5A5A_0005);
        exp_q.push_back(32'hFFFF_0006);
        exp_q.push_back(32'h0000_0007);
        @(negedge clk);
        arm = 1'b1;
        state_cycle(32'h1111_0001, 1'b1, 1'b0);  // R6 pre-trigger
        state_cycle(32'h2222_0002, 1'b0, 1'b1);  // R5 unqualified trigger
        state_cycle(32'hA5A5_0003, 1'b1, 1'b1);  // trigger
        mode_sel = 1'b0;                         // R8: must be ignored
        state_cycle(32'h4444_0004, 1'b0, 1'b0);  // R4 skipped edge
        state_cycle(32'h5A5A_0005, 1'b1, 1'b0);
        state_cycle(32'hFFFF_0006, 1'b1, 1'b1);
        state_cycle(32'h0000_0007, 1'b1, 1'b0);
        check(done == 1'b1, "R7 done after state capture", done, 1);
        state_cycle(32'h8888_0008, 1'b1, 1'b0);  // R9 no write after done
        ext_clk = 1'b0; qual = 1'b0;
        disarm_check();

        // Timing mode, post_len 0: single write (R7 boundary).
        mode_sel = 1'b0; post_len = 8'd0;
        exp_q.push_back(32'hDEAD_BEEF);
        @(negedge clk);
        arm = 1'b1;
        repeat (3) @(negedge clk);
        din = 32'hDEAD_BEEF; trig = 1'b1;
        @(negedge clk);
        din = 32'h0BAD_0BAD; trig = 1'b0;
        repeat (3) @(negedge clk);
        check(done == 1'b1, "R7 single-sample done", done, 1);
        disarm_check();

        $display("Result: errors=%0d of %0d checks", errs + mon_errs, checks + mon_checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog: act=timeout exp=finish");
        $display("Result: errors=%0d of %0d checks", errs + mon_errs + 1, checks + mon_checks + 1);
        $finish;
    end

endmodule